// File: doc/BRIEF.md
# Swizzle Context Operand Scheduler

This block keeps a small set of swizzle contexts. Each context holds a three-bit source-operand mask and two 12-bit swizzle patterns. Each context also has a per-slot queue of schedule bits, and that queue says to which upcoming vector-prefixed instructions the context applies. A loader hands the block one context at a time, together with a 17-bit schedule. The schedule bits go onto the end of whatever is still queued for that slot, and the slot's mask and patterns are replaced.

Each time a vector-prefixed instruction issues, every slot whose queue head is set takes part. An instruction that got its prefix through propagation counts as vector-prefixed. The masks and patterns of all taking-part slots are OR-merged. The first merged pattern goes to the lowest-numbered masked source operand and the second pattern to the next one. Every queue then moves forward by one. Plain instructions leave the queues unchanged. The per-operand enables, patterns and an error flag come out combinationally in the cycle of the issue, ready for a downstream permutation datapath.

The load side is a valid/ready stream. The block holds `ld_ready` low while the addressed slot cannot take the schedule. A held load must keep its fields stable, and it is taken on the first clock edge where valid and ready are both high.

Top module: `swz_ctx_sched`

## Requirements
- R1: After reset every slot queue is empty, `ld_ready` is high, and a vector issue produces no enables, zero patterns and no error.
- R2: An accepted load (`ld_valid` and `ld_ready` high at a clock edge) to slot s appends its schedule to that slot's queue. The schedule length is the position of its highest set bit plus one, and bit k of `ld_sched` (bit 0 first) marks the k-th vector issue after all bits already queued for slot s.
- R3: The queues advance only on a vector issue (`iss_valid` and `iss_vec` both high). A plain issue (`iss_vec` low) gets no swizzle and does not consume a schedule position.
- R4: Outputs are combinational in the cycle of a vector issue. Without a vector issue, `src_swz_en` and `swz_err` are 0 and `src_swz_pat` is zero.
- R5: On a vector issue, the masks and both patterns of all slots whose queue head is set are OR-merged, so that one slot may give only the mask and another only the patterns.
- R6: `src_swz_en` bit k enables source operand k+1 (mask bit 0 = src1, bit 1 = src2, bit 2 = src3), and that operand's pattern is `src_swz_pat[12k+11:12k]`. The lowest-numbered masked source gets pattern A and the next masked source gets pattern B. A source that is not enabled has a zero pattern.
- R7: When exactly one merged mask bit is set, only pattern A is used and pattern B has no effect on the outputs.
- R8: When all three merged mask bits are set, src3 gets no swizzle, and `swz_err` is high in that cycle.
- R9: When the merged mask is zero, no source is enabled, even if the patterns are nonzero.
- R10: `ld_ready` is low when the queued depth of the addressed slot plus the schedule length exceeds 40. It goes high once enough vector issues have drained that slot.
- R11: A load to a slot replaces that slot's mask and patterns from the next cycle on. A load with an all-zero schedule changes only the context.
- R12: A load whose slot index is 7 or more is accepted (`ld_ready` high) and has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Context load offered |
| ld_ready | output | 1 | Context load can be taken |
| ld_slot | input | 3 | Context slot index (0 to 6 valid) |
| ld_mask | input | 3 | Source-operand mask of the context |
| ld_swz_a | input | 12 | First swizzle pattern |
| ld_swz_b | input | 12 | Second swizzle pattern |
| ld_sched | input | 17 | Schedule bits, bit 0 = earliest |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_vec | input | 1 | Issuing instruction is vector-prefixed (direct or propagated) |
| src_swz_en | output | 3 | Per-source swizzle enable, bit 0 = src1 |
| src_swz_pat | output | 36 | Per-source swizzle pattern, 12 bits each, src1 lowest |
| swz_err | output | 1 | More than two sources masked |

## Verification
An error in a slot's depth counter shows on `ld_ready` in the same cycle that a load addresses that slot. It also shows as swizzle activity one or more vector issues early or late. A corrupted context or queue bit stays hidden while only plain instructions issue. It appears at the ports in the exact cycle of the vector issue whose queue position it covers. For that reason the stimulus interleaves plain issues, simultaneous load-and-issue cycles, and long drains before the checked issue.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int NSRC  = 3;
  localparam int PAT_W = 12;

  typedef struct packed {
    logic [NSRC-1:0]  mask;
    logic [PAT_W-1:0] swz_a;
    logic [PAT_W-1:0] swz_b;
  } swz_ctx_t;
endpackage

// File: rtl/swz_slot.sv
module swz_slot
  import swz_pkg::*;
#(
  parameter int SCHED_W  = 17,
  parameter int SREG_LEN = 40,
  parameter int DEPTH_W  = 6,
  parameter int LEN_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  swz_ctx_t           wr_ctx,
  input  logic [SCHED_W-1:0] wr_sched,
  input  logic [LEN_W-1:0]   wr_len,
  input  logic               adv,
  output logic               active,
  output swz_ctx_t           ctx,
  output logic [DEPTH_W-1:0] depth
);
  logic [SREG_LEN-1:0] sreg;
  logic [SREG_LEN-1:0] base_sreg;
  logic [DEPTH_W-1:0]  base_depth;
  logic [SREG_LEN-1:0] ext_sched;

  assign active    = sreg[0];
  assign ext_sched = {{(SREG_LEN-SCHED_W){1'b0}}, wr_sched};

  always_comb begin
    base_sreg  = adv ? (sreg >> 1) : sreg;
    base_depth = (adv && depth != '0) ? depth - 1'b1 : depth;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg  <= '0;
      depth <= '0;
      ctx   <= '0;
    end else if (wr) begin
      sreg  <= base_sreg | (ext_sched << base_depth);
      depth <= base_depth + DEPTH_W'(wr_len);
      ctx   <= wr_ctx;
    end else begin
      sreg  <= base_sreg;
      depth <= base_depth;
    end
  end
endmodule

// File: rtl/swz_merge.sv
module swz_merge
  import swz_pkg::*;
#(
  parameter int NUM_CTX = 7
) (
  input  logic [NUM_CTX-1:0] active,
  input  swz_ctx_t           ctx_in [NUM_CTX],
  output swz_ctx_t           merged
);
  always_comb begin
    merged = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (active[i]) merged = merged | ctx_in[i];
    end
  end
endmodule

// File: rtl/swz_route.sv
module swz_route
  import swz_pkg::*;
(
  input  logic                  fire,
  input  swz_ctx_t              merged,
  output logic [NSRC-1:0]       en,
  output logic [NSRC*PAT_W-1:0] pat,
  output logic                  err
);
  logic [1:0] used;

  always_comb begin
    en   = '0;
    pat  = '0;
    err  = 1'b0;
    used = 2'd0;
    if (fire) begin
      for (int k = 0; k < NSRC; k++) begin
        if (merged.mask[k]) begin
          if (used == 2'd0) begin
            en[k]                = 1'b1;
            pat[k*PAT_W +: PAT_W] = merged.swz_a;
            used                 = 2'd1;
          end else if (used == 2'd1) begin
            en[k]                = 1'b1;
            pat[k*PAT_W +: PAT_W] = merged.swz_b;
            used                 = 2'd2;
          end else begin
            err = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/swz_ctx_sched.sv
module swz_ctx_sched
  import swz_pkg::*;
#(
  parameter int NUM_CTX  = 7,
  parameter int SCHED_W  = 17,
  parameter int SREG_LEN = 40,
  parameter int SLOT_W   = $clog2(NUM_CTX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_valid,
  output logic                  ld_ready,
  input  logic [SLOT_W-1:0]     ld_slot,
  input  logic [NSRC-1:0]       ld_mask,
  input  logic [PAT_W-1:0]      ld_swz_a,
  input  logic [PAT_W-1:0]      ld_swz_b,
  input  logic [SCHED_W-1:0]    ld_sched,
  input  logic                  iss_valid,
  input  logic                  iss_vec,
  output logic [NSRC-1:0]       src_swz_en,
  output logic [NSRC*PAT_W-1:0] src_swz_pat,
  output logic                  swz_err
);
  localparam int DEPTH_W = $clog2(SREG_LEN + 1);
  localparam int LEN_W   = $clog2(SCHED_W + 1);

  logic               adv;
  logic               accept;
  logic               slot_hit;
  logic [LEN_W-1:0]   ld_len;
  logic [DEPTH_W-1:0] sel_depth;
  logic [NUM_CTX-1:0] active;
  logic [NUM_CTX-1:0] wr;
  logic [DEPTH_W-1:0] depth [NUM_CTX];
  swz_ctx_t           ctx   [NUM_CTX];
  swz_ctx_t           new_ctx;
  swz_ctx_t           merged;

  assign adv     = iss_valid & iss_vec;
  assign new_ctx = '{mask: ld_mask, swz_a: ld_swz_a, swz_b: ld_swz_b};

  always_comb begin
    ld_len = '0;
    for (int k = 0; k < SCHED_W; k++) begin
      if (ld_sched[k]) ld_len = LEN_W'(k + 1);
    end
  end

  always_comb begin
    slot_hit  = 1'b0;
    sel_depth = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (ld_slot == SLOT_W'(i)) begin
        slot_hit  = 1'b1;
        sel_depth = depth[i];
      end
    end
  end

  assign ld_ready = !slot_hit || ((int'(sel_depth) + int'(ld_len)) <= SREG_LEN);
  assign accept   = ld_valid & ld_ready;

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
    assign wr[i] = accept && (ld_slot == SLOT_W'(i));

    swz_slot #(
      .SCHED_W (SCHED_W),
      .SREG_LEN(SREG_LEN),
      .DEPTH_W (DEPTH_W),
      .LEN_W   (LEN_W)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr[i]),
      .wr_ctx  (new_ctx),
      .wr_sched(ld_sched),
      .wr_len  (ld_len),
      .adv     (adv),
      .active  (active[i]),
      .ctx     (ctx[i]),
      .depth   (depth[i])
    );
  end

  swz_merge #(.NUM_CTX(NUM_CTX)) u_merge (
    .active(active),
    .ctx_in(ctx),
    .merged(merged)
  );

  swz_route u_route (
    .fire  (adv),
    .merged(merged),
    .en    (src_swz_en),
    .pat   (src_swz_pat),
    .err   (swz_err)
  );
endmodule

// File: rtl/swz_ctx_sched_chk.sv
module swz_ctx_sched_chk
  import swz_pkg::*;
#(
  parameter int SCHED_W = 17,
  parameter int SLOT_W  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ld_valid,
  input logic                  ld_ready,
  input logic [SLOT_W-1:0]     ld_slot,
  input logic [SCHED_W-1:0]    ld_sched,
  input logic                  iss_valid,
  input logic                  iss_vec,
  input logic [NSRC-1:0]       src_swz_en,
  input logic [NSRC*PAT_W-1:0] src_swz_pat,
  input logic                  swz_err
);
  // R4: no vector issue, no swizzle activity
  p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid && iss_vec) |-> (src_swz_en == '0 && !swz_err && src_swz_pat == '0));

  // R6: a source that is not enabled carries a zero pattern
  p_off_src1_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !src_swz_en[0] |-> src_swz_pat[PAT_W-1:0] == '0);
  p_off_src2_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !src_swz_en[1] |-> src_swz_pat[2*PAT_W-1:PAT_W] == '0);
  p_off_src3_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !src_swz_en[2] |-> src_swz_pat[3*PAT_W-1:2*PAT_W] == '0);

  // R8: at most two sources swizzled; error means src1 and src2 only
  p_two_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_swz_en) <= 2);
  p_err_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swz_err |-> src_swz_en == 3'b011);

  // R10: a refused load stays refused while nothing drains and its fields hold
  p_hold_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready && !(iss_valid && iss_vec)) |=>
      (!($stable(ld_slot) && $stable(ld_sched)) || !ld_ready));
endmodule

bind swz_ctx_sched swz_ctx_sched_chk #(.SCHED_W(SCHED_W), .SLOT_W(SLOT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ld_valid   (ld_valid),
  .ld_ready   (ld_ready),
  .ld_slot    (ld_slot),
  .ld_sched   (ld_sched),
  .iss_valid  (iss_valid),
  .iss_vec    (iss_vec),
  .src_swz_en (src_swz_en),
  .src_swz_pat(src_swz_pat),
  .swz_err    (swz_err)
);

// File: tb/sim_swz_ctx_sched.sv
module sim_swz_ctx_sched;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid;
  logic        ld_ready;
  logic [2:0]  ld_slot;
  logic [2:0]  ld_mask;
  logic [11:0] ld_swz_a;
  logic [11:0] ld_swz_b;
  logic [16:0] ld_sched;
  logic        iss_valid;
  logic        iss_vec;
  logic [2:0]  src_swz_en;
  logic [35:0] src_swz_pat;
  logic        swz_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  swz_ctx_sched u0 (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_slot(ld_slot),
    .ld_mask(ld_mask), .ld_swz_a(ld_swz_a), .ld_swz_b(ld_swz_b),
    .ld_sched(ld_sched), .iss_valid(iss_valid), .iss_vec(iss_vec),
    .src_swz_en(src_swz_en), .src_swz_pat(src_swz_pat), .swz_err(swz_err)
  );

  typedef struct packed {
    logic        ld;
    logic [2:0]  slot;
    logic [2:0]  mask;
    logic [11:0] a;
    logic [11:0] b;
    logic [16:0] sch;
    logic        vec;
    logic        plain;
    logic [2:0]  en;
    logic [35:0] pat;
    logic        err;
  } row_t;

  localparam int NROW = 12;
  localparam row_t TBL [NROW] = '{
    '{1'b1, 3'd0, 3'b001, 12'h111, 12'h222, 17'b101, 1'b0, 1'b0, 3'b000, 36'h0, 1'b0},
    '{1'b0, 3'd0, 3'b000, 12'h000, 12'h000, 17'd0,   1'b1, 1'b0, 3'b001, 36'h000000111, 1'b0},
    '{1'b0, 3'd0, 3'b000, 12'h000, 12'h000, 17'd0,   1'b0, 1'b1, 3'b000, 36'h0, 1'b0},
    '{1'b0, 3'd0, 3'b000, 12'h000, 12'h000, 17'd0,   1'b1, 1'b0, 3'b000, 36'h0, 1'b0},
    '{1'b1, 3'd1, 3'b110, 12'h000, 12'h000, 17'd1,   1'b0, 1'b0, 3'b000, 36'h0, 1'b0},
    '{1'b0, 3'd0, 3'b000, 12'h000, 12'h000, 17'd0,   1'b1, 1'b0, 3'b011, 36'h000222111, 1'b1},
    '{1'b1, 3'd2, 3'b110, 12'h0F0, 12'h00F, 17'd1,   1'b1, 1'b0, 3'b000, 36'h0, 1'b0},
    '{1'b0, 3'd0, 3'b000, 12'h000, 12'h000, 17'd0,   1'b1, 1'b0, 3'b110, 36'h00F0F0000, 1'b0},
    '{1'b1, 3'd3, 3'b000, 12'hABC, 12'hDEF, 17'd1,   1'b0, 1'b0, 3'b000, 36'h0, 1'b0},
    '{1'b0, 3'd0, 3'b000, 12'h000, 12'h000, 17'd0,   1'b1, 1'b0, 3'b000, 36'h0, 1'b0},
    '{1'b1, 3'd4, 3'b100, 12'h5A5, 12'h777, 17'd1,   1'b0, 1'b0, 3'b000, 36'h0, 1'b0},
    '{1'b0, 3'd0, 3'b000, 12'h000, 12'h000, 17'd0,   1'b1, 1'b0, 3'b100, 36'h5A5000000, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [2:0] en, input logic [35:0] pat,
                           input logic err);
    check({req, " en"}, 64'(src_swz_en), 64'(en));
    check({req, " pat"}, 64'(src_swz_pat), 64'(pat));
    check({req, " err"}, 64'(swz_err), 64'(err));
  endtask

  task automatic idle();
    ld_valid = 1'b0; ld_slot = '0; ld_mask = '0; ld_swz_a = '0; ld_swz_b = '0;
    ld_sched = '0; iss_valid = 1'b0; iss_vec = 1'b0;
  endtask

  task automatic set_load(input logic [2:0] s, input logic [2:0] m, input logic [11:0] a,
                          input logic [11:0] b, input logic [16:0] sch);
    ld_valid = 1'b1; ld_slot = s; ld_mask = m; ld_swz_a = a; ld_swz_b = b; ld_sched = sch;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: state after reset
    iss_valid = 1'b1; iss_vec = 1'b1;
    #1;
    check("R1 ready", 64'(ld_ready), 64'd1);
    check_out("R1 idle", 3'b000, 36'h0, 1'b0);
    @(posedge clk);

    // R2..R9 table
    for (int r = 0; r < NROW; r++) begin
      @(negedge clk);
      idle();
      if (TBL[r].ld) set_load(TBL[r].slot, TBL[r].mask, TBL[r].a, TBL[r].b, TBL[r].sch);
      if (TBL[r].vec)   begin iss_valid = 1'b1; iss_vec = 1'b1; end
      if (TBL[r].plain) begin iss_valid = 1'b1; iss_vec = 1'b0; end
      #1;
      if (TBL[r].ld) check($sformatf("R2 row%0d ready", r), 64'(ld_ready), 64'd1);
      check_out($sformatf("R2-row%0d R3 R5 R6 R7 R8 R9", r), TBL[r].en, TBL[r].pat, TBL[r].err);
      @(posedge clk);
    end

    // R10: slot 5 filled to depth 34, third 17-long load must wait
    @(negedge clk); idle(); set_load(3'd5, 3'b010, 12'h123, 12'h456, 17'h10000);
    @(posedge clk);
    @(negedge clk); set_load(3'd5, 3'b010, 12'h123, 12'h456, 17'h10000);
    @(posedge clk);
    for (int c = 0; c < 11; c++) begin
      @(negedge clk);
      set_load(3'd5, 3'b010, 12'h123, 12'h456, 17'h10000);
      iss_valid = 1'b1; iss_vec = 1'b1;
      #1;
      check($sformatf("R10 held cycle %0d", c), 64'(ld_ready), 64'd0);
      check_out("R10 drain quiet", 3'b000, 36'h0, 1'b0);
      @(posedge clk);
    end
    @(negedge clk);
    iss_valid = 1'b0; iss_vec = 1'b0;
    #1;
    check("R10 ready after drain", 64'(ld_ready), 64'd1);
    @(posedge clk);
    // R2: queued bits now at positions 5, 22, 39 of slot 5
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      idle();
      iss_valid = 1'b1; iss_vec = 1'b1;
      #1;
      if (c < 5) check_out("R2 append wait", 3'b000, 36'h0, 1'b0);
      else       check_out("R2 append hit", 3'b010, 36'h000123000, 1'b0);
      @(posedge clk);
    end

    // R11: reload slot 6 context with empty schedule
    @(negedge clk); idle(); set_load(3'd6, 3'b001, 12'h001, 12'h0, 17'd1);
    @(posedge clk);
    @(negedge clk); idle(); set_load(3'd6, 3'b100, 12'h002, 12'h0, 17'd0);
    #1; check("R11 ready", 64'(ld_ready), 64'd1);
    @(posedge clk);
    @(negedge clk); idle(); iss_valid = 1'b1; iss_vec = 1'b1;
    #1; check_out("R11 replaced", 3'b100, 36'h002000000, 1'b0);
    @(posedge clk);

    // R12: out-of-range slot
    @(negedge clk); idle(); set_load(3'd7, 3'b001, 12'hFFF, 12'hFFF, 17'd1);
    #1; check("R12 ready", 64'(ld_ready), 64'd1);
    @(posedge clk);
    @(negedge clk); idle(); iss_valid = 1'b1; iss_vec = 1'b1;
    #1; check_out("R12 no effect", 3'b000, 36'h0, 1'b0);
    @(posedge clk);

    // R1: reset clears pending slot 5 bits and depth
    @(negedge clk); idle(); rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    set_load(3'd5, 3'b001, 12'h0, 12'h0, 17'h10000);
    #1; check("R1 depth cleared", 64'(ld_ready), 64'd1);
    idle();
    for (int c = 0; c < 20; c++) begin
      iss_valid = 1'b1; iss_vec = 1'b1;
      #1; check_out("R1 queues cleared", 3'b000, 36'h0, 1'b0);
      @(posedge clk);
      @(negedge clk);
    end

    done = 1'b1;
    finish_run();
  end
endmodule